// File: doc/BRIEF.md
# Prefixed Instruction Fetch Sequencer

This block is the instruction front end of a coprocessor with 8-bit opcodes. It keeps one prefetched byte in a pipe register. On every active step it hands that byte on for execution while it reads the next byte from program memory at the address formed by the program bank and the 16-bit program counter. Each dispatched opcode is paired with two pending mode bits to form a 10-bit dispatch index. The sequencer also reports which registers the following instruction uses as source and destination.

Prefix opcodes are absorbed by the sequencer and are never dispatched. One group sets the two mode bits. Another group selects the source register, the destination register, or both. The last group also raises a sticky "both selected" flag. This prefix state is kept across prefix bytes and returns to its defaults once an ordinary instruction has been dispatched. When an ordinary instruction names register 14 as its destination, the sequencer starts a data read at register 14's value in the data bank. It shows a busy bit until that read is acknowledged, and it latches the returned byte. A start pulse primes the pipe and sets the run flag. A stop opcode clears the run flag, and the sequencer then holds still.

Top module: `fx_fetch_seq`

## Requirements
- R1: On a start pulse, program memory is read at {prog_bank_i, start_pc_i} into the pipe. On each later running step, the address presented is {prog_bank_i, PC}, and that byte becomes the new pipe content. In the cycle after it is fetched, that byte appears as dispatch_idx_o[7:0].
- R2: dispatch_idx_o is {mode bit B, mode bit A, pipe byte}. Mode bit A is status_o[8] and mode bit B is status_o[9].
- R3: Opcodes 0x3D, 0x3E and 0x3F are mode prefixes. They set mode bit A, mode bit B, or both, and these settings accumulate. They are never dispatched (dispatch_valid_o stays 0), and the mode carries over to the next opcode. All other non-prefix opcodes raise dispatch_valid_o while running.
- R4: In the cycle after an ordinary or stop opcode is dispatched, mode bits A and B, the both-selected flag (status_o[12]), and both register selections are 0.
- R5: 0x1n selects destination n. 0xBn selects source n. 0x2n selects both as n and sets status_o[12]. All three are prefixes in every mode, and none of them is dispatched.
- R6: An ordinary instruction dispatched with destination 14 pulses rom_rd_o in that cycle, with rom_addr_o = {rom_bank_i, r14_i}. From the next cycle, status_o[6] reads 1 until a cycle in which rom_ack_i is seen. In that cycle rom_data_i is latched into rom_buf_o, and status_o[6] reads 0 from the next cycle unless a new read starts.
- R7: PC advances by one per fetch and wraps from 0xFFFF to 0x0000. The bank part of the address is not affected.
- R8: Opcode 0x00 stops the sequencer: it is dispatched and status_o[5] (run flag) clears. While stopped, the fetch address offset and the pipe are held and dispatch_valid_o is 0 until the next start_i. A start_i pulse, even while running, restarts the sequencer with default prefix state.
- R9: After reset, status_o is 0, dispatch_valid_o and rom_rd_o are 0, and both selections are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse, primes pipe at start_pc_i |
| start_pc_i | input | 16 | Start program counter |
| prog_bank_i | input | 8 | Program bank |
| rom_bank_i | input | 8 | Data read bank |
| pmem_addr_o | output | 24 | Program memory address {bank, offset} |
| pmem_data_i | input | 8 | Program memory byte (same-cycle read) |
| r14_i | input | 16 | Current value of register 14 |
| rom_rd_o | output | 1 | Data read request pulse |
| rom_addr_o | output | 24 | Data read address {rom bank, r14} |
| rom_ack_i | input | 1 | Data read acknowledge |
| rom_data_i | input | 8 | Data read byte |
| rom_buf_o | output | 8 | Last acknowledged data byte |
| dispatch_valid_o | output | 1 | An ordinary opcode is dispatched this cycle |
| dispatch_idx_o | output | 10 | {mode B, mode A, opcode} |
| src_sel_o | output | 4 | Selected source register |
| dst_sel_o | output | 4 | Selected destination register |
| status_o | output | 16 | Bit 5 run, 6 read busy, 8 mode A, 9 mode B, 12 both-selected |

## Verification
Random programs mix mode prefixes, register-select prefixes, ordinary opcodes and occasional stops. Chains of mode prefixes show whether the mode bits accumulate or only keep the last prefix. Register-select chains that end on register 14 show whether the data read starts, and whether the busy bit and buffer follow a randomly timed acknowledge. Restarts near offset 0xFFFF, long stopped stretches, and restarts issued while running show the wrap, the hold and the priority of the start pulse over a running step.

// File: rtl/fx_seq_pkg.sv
// Package: opcode classes and the opcode values the sequencer decodes itself.
// Assumes an 8-bit opcode; all other instruction semantics live downstream.
package fx_seq_pkg;

    localparam int OP_W = 8;

    typedef enum logic [2:0] {
        K_ORD,
        K_STOP,
        K_MODE,
        K_DST,
        K_SRC,
        K_BOTH
    } op_kind_e;

    localparam logic [OP_W-1:0] OPC_STOP  = 8'h00;
    localparam logic [OP_W-1:0] OPC_MODEA = 8'h3D;
    localparam logic [OP_W-1:0] OPC_MODEB = 8'h3E;
    localparam logic [OP_W-1:0] OPC_MODEC = 8'h3F;
    localparam logic [3:0]      GRP_DST   = 4'h1;
    localparam logic [3:0]      GRP_BOTH  = 4'h2;
    localparam logic [3:0]      GRP_SRC   = 4'hB;

    // Sort an opcode into the class the sequencer acts on.
    function automatic op_kind_e classify(input logic [OP_W-1:0] op);
        op_kind_e k;
        if (op == OPC_STOP)                                   k = K_STOP;
        else if (op == OPC_MODEA || op == OPC_MODEB || op == OPC_MODEC) k = K_MODE;
        else if (op[7:4] == GRP_DST)                          k = K_DST;
        else if (op[7:4] == GRP_BOTH)                         k = K_BOTH;
        else if (op[7:4] == GRP_SRC)                          k = K_SRC;
        else                                                  k = K_ORD;
        return k;
    endfunction

endpackage

// File: rtl/fx_fetch_pipe.sv
// Fetch pipe: holds the program counter and the one-byte prefetch register.
// Assumes program memory returns the byte in the same cycle as the address.
// A start pulse primes the pipe from start_pc; each running step refills it.
module fx_fetch_pipe #(
    parameter int PC_W   = 16,
    parameter int BANK_W = 8,
    parameter int OP_W   = 8,
    localparam int AW    = BANK_W + PC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [PC_W-1:0]   start_pc_i,
    input  logic              run_i,
    input  logic [BANK_W-1:0] bank_i,
    input  logic [OP_W-1:0]   mem_data_i,
    output logic [AW-1:0]     mem_addr_o,
    output logic [OP_W-1:0]   pipe_o
);

    logic [PC_W-1:0] pc_q;
    logic [OP_W-1:0] pipe_q;
    logic [PC_W-1:0] fetch_pc;

    // Offset used for this cycle's fetch: start address wins over the counter.
    always_comb fetch_pc = start_i ? start_pc_i : pc_q;

    assign mem_addr_o = {bank_i, fetch_pc};
    assign pipe_o     = pipe_q;

    // Load the pipe and advance the counter on start or on a running step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q   <= '0;
            pipe_q <= '0;
        end else if (start_i || run_i) begin
            pipe_q <= mem_data_i;
            pc_q   <= fetch_pc + PC_W'(1);
        end
    end

endmodule

// File: rtl/fx_prefix_state.sv
// Prefix state: the two mode bits, the both-selected flag and register selects.
// Assumes step_i is high only for a running, non-start cycle. Prefix classes
// update state and suppress dispatch; ordinary and stop opcodes clear it.
module fx_prefix_state #(
    parameter int REG_W = 4,
    parameter int OP_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             step_i,
    input  logic [OP_W-1:0]  op_i,
    output logic             mode_a_o,
    output logic             mode_b_o,
    output logic             both_o,
    output logic [REG_W-1:0] src_o,
    output logic [REG_W-1:0] dst_o,
    output logic             dispatch_o,
    output logic             stop_o
);
    import fx_seq_pkg::*;

    op_kind_e kind;
    logic     mode_a_q, mode_b_q, both_q;
    logic [REG_W-1:0] src_q, dst_q;

    // Classify the byte currently in the pipe.
    always_comb kind = classify(op_i);

    // Dispatch and stop strobes for the current step.
    always_comb begin
        dispatch_o = step_i && (kind == K_ORD || kind == K_STOP);
        stop_o     = step_i && (kind == K_STOP);
    end

    // Accumulate prefixes; clear after an ordinary instruction or on start.
    always_ff @(posedge clk) begin
        if (!rst_n || start_i) begin
            mode_a_q <= 1'b0;
            mode_b_q <= 1'b0;
            both_q   <= 1'b0;
            src_q    <= '0;
            dst_q    <= '0;
        end else if (step_i) begin
            case (kind)
                K_MODE: begin
                    mode_a_q <= mode_a_q | op_i[0];
                    mode_b_q <= mode_b_q | op_i[1];
                end
                K_DST:  dst_q <= op_i[REG_W-1:0];
                K_SRC:  src_q <= op_i[REG_W-1:0];
                K_BOTH: begin
                    src_q  <= op_i[REG_W-1:0];
                    dst_q  <= op_i[REG_W-1:0];
                    both_q <= 1'b1;
                end
                default: begin
                    mode_a_q <= 1'b0;
                    mode_b_q <= 1'b0;
                    both_q   <= 1'b0;
                    src_q    <= '0;
                    dst_q    <= '0;
                end
            endcase
        end
    end

    assign mode_a_o = mode_a_q;
    assign mode_b_o = mode_b_q;
    assign both_o   = both_q;
    assign src_o    = src_q;
    assign dst_o    = dst_q;

endmodule

// File: rtl/fx_rom_track.sv
// Data read tracker: busy flag and buffer for reads triggered by register 14.
// Assumes the memory side answers each request with a single ack cycle.
module fx_rom_track #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              ack_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              busy_o,
    output logic [DATA_W-1:0] buf_o
);

    logic              busy_q;
    logic [DATA_W-1:0] buf_q;

    // A new request sets busy; an ack on a pending read clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)              busy_q <= 1'b0;
        else if (req_i)          busy_q <= 1'b1;
        else if (ack_i)          busy_q <= 1'b0;
    end

    // Capture returned data when a pending read is acknowledged.
    always_ff @(posedge clk) begin
        if (!rst_n)                 buf_q <= '0;
        else if (busy_q && ack_i)   buf_q <= data_i;
    end

    assign busy_o = busy_q;
    assign buf_o  = buf_q;

endmodule

// File: rtl/fx_fetch_seq.sv
// Top: prefixed instruction fetch sequencer. Owns the run flag, ties the fetch
// pipe, prefix state and data read tracker together, and forms the dispatch
// index and the status word. Assumes same-cycle program memory reads.
module fx_fetch_seq #(
    parameter int PC_W   = 16,
    parameter int BANK_W = 8,
    parameter int REG_W  = 4,
    localparam int OP_W  = 8,
    localparam int AW    = BANK_W + PC_W,
    localparam int IDX_W = OP_W + 2,
    localparam int ST_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [PC_W-1:0]   start_pc_i,
    input  logic [BANK_W-1:0] prog_bank_i,
    input  logic [BANK_W-1:0] rom_bank_i,
    output logic [AW-1:0]     pmem_addr_o,
    input  logic [OP_W-1:0]   pmem_data_i,
    input  logic [PC_W-1:0]   r14_i,
    output logic              rom_rd_o,
    output logic [AW-1:0]     rom_addr_o,
    input  logic              rom_ack_i,
    input  logic [OP_W-1:0]   rom_data_i,
    output logic [OP_W-1:0]   rom_buf_o,
    output logic              dispatch_valid_o,
    output logic [IDX_W-1:0]  dispatch_idx_o,
    output logic [REG_W-1:0]  src_sel_o,
    output logic [REG_W-1:0]  dst_sel_o,
    output logic [ST_W-1:0]   status_o
);

    localparam logic [REG_W-1:0] ROM_PTR_REG = REG_W'(14);

    logic            run_q;
    logic            step;
    logic [OP_W-1:0] pipe;
    logic            mode_a, mode_b, both;
    logic            dispatch, stop_hit, busy;

    // A running step happens whenever running and not being restarted.
    always_comb step = run_q && !start_i;

    // Run flag: set by start, cleared after a stop opcode is dispatched.
    always_ff @(posedge clk) begin
        if (!rst_n)        run_q <= 1'b0;
        else if (start_i)  run_q <= 1'b1;
        else if (stop_hit) run_q <= 1'b0;
    end

    fx_fetch_pipe #(.PC_W(PC_W), .BANK_W(BANK_W), .OP_W(OP_W)) u_pipe (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .start_pc_i (start_pc_i),
        .run_i      (step),
        .bank_i     (prog_bank_i),
        .mem_data_i (pmem_data_i),
        .mem_addr_o (pmem_addr_o),
        .pipe_o     (pipe)
    );

    fx_prefix_state #(.REG_W(REG_W), .OP_W(OP_W)) u_prefix (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .step_i     (step),
        .op_i       (pipe),
        .mode_a_o   (mode_a),
        .mode_b_o   (mode_b),
        .both_o     (both),
        .src_o      (src_sel_o),
        .dst_o      (dst_sel_o),
        .dispatch_o (dispatch),
        .stop_o     (stop_hit)
    );

    // Request a data read when an ordinary instruction writes register 14.
    always_comb rom_rd_o = dispatch && (dst_sel_o == ROM_PTR_REG);
    assign rom_addr_o = {rom_bank_i, r14_i};

    fx_rom_track #(.DATA_W(OP_W)) u_rom (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (rom_rd_o),
        .ack_i  (rom_ack_i),
        .data_i (rom_data_i),
        .busy_o (busy),
        .buf_o  (rom_buf_o)
    );

    // Dispatch outputs and the status word.
    always_comb begin
        dispatch_valid_o = dispatch;
        dispatch_idx_o   = {mode_b, mode_a, pipe};
        status_o         = '0;
        status_o[5]      = run_q;
        status_o[6]      = busy;
        status_o[8]      = mode_a;
        status_o[9]      = mode_b;
        status_o[12]     = both;
    end

endmodule

// File: rtl/fx_seq_checker.sv
// Checker: temporal properties of the sequencer, bound to the top module.
module fx_seq_checker #(
    parameter int PC_W   = 16,
    parameter int BANK_W = 8,
    parameter int REG_W  = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   start_i,
    input logic [BANK_W+PC_W-1:0] pmem_addr_o,
    input logic                   dispatch_valid_o,
    input logic [9:0]             dispatch_idx_o,
    input logic [REG_W-1:0]       src_sel_o,
    input logic [REG_W-1:0]       dst_sel_o,
    input logic [15:0]            status_o,
    input logic                   rom_rd_o
);

    // R7: offset advances by one per running step, wrapping in 16 bits.
    p_pc_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[5] && !start_i) |=> (start_i ||
            pmem_addr_o[PC_W-1:0] == PC_W'($past(pmem_addr_o[PC_W-1:0]) + 1)));

    // R8: stopped sequencer holds its fetch offset.
    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!status_o[5] && !start_i) |=> (start_i ||
            pmem_addr_o[PC_W-1:0] == $past(pmem_addr_o[PC_W-1:0])));

    // R8: nothing dispatched while stopped.
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !status_o[5] |-> !dispatch_valid_o);

    // R4: prefix state is back to defaults after a dispatch.
    p_clear_after_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dispatch_valid_o |=> (status_o[9:8] == 2'b00 && !status_o[12] &&
                              src_sel_o == '0 && dst_sel_o == '0));

    // R3: mode prefix is absorbed and its bit is visible next cycle.
    p_mode_prefix_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[5] && !start_i && dispatch_idx_o[7:0] == 8'h3F)
            |=> (status_o[8] && status_o[9]));

    // R3: mode prefix opcodes never appear as a dispatch.
    p_no_mode_dispatch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dispatch_valid_o |-> !(dispatch_idx_o[7:0] inside {8'h3D, 8'h3E, 8'h3F}));

    // R6: a data read request shows busy the next cycle.
    p_rom_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rom_rd_o |=> status_o[6]);

endmodule

bind fx_fetch_seq fx_seq_checker #(.PC_W(PC_W), .BANK_W(BANK_W), .REG_W(REG_W)) i_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .start_i          (start_i),
    .pmem_addr_o      (pmem_addr_o),
    .dispatch_valid_o (dispatch_valid_o),
    .dispatch_idx_o   (dispatch_idx_o),
    .src_sel_o        (src_sel_o),
    .dst_sel_o        (dst_sel_o),
    .status_o         (status_o),
    .rom_rd_o         (rom_rd_o)
);

// File: tb/test_fx_fetch_seq.sv
module test_fx_fetch_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] start_pc = '0;
    logic [7:0]  pbank = '0, rbank = '0;
    logic [23:0] paddr;
    logic [7:0]  pdata;
    logic [15:0] r14 = '0;
    logic        rom_rd;
    logic [23:0] rom_addr;
    logic        ack = 1'b0;
    logic [7:0]  rdata = '0;
    logic [7:0]  rbuf;
    logic        dval;
    logic [9:0]  didx;
    logic [3:0]  src, dst;
    logic [15:0] status;

    logic [7:0] mem [0:255];
    assign pdata = mem[paddr[7:0]];

    always #10 clk = ~clk;

    fx_fetch_seq i_fx_fetch_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start), .start_pc_i(start_pc),
        .prog_bank_i(pbank), .rom_bank_i(rbank), .pmem_addr_o(paddr),
        .pmem_data_i(pdata), .r14_i(r14), .rom_rd_o(rom_rd), .rom_addr_o(rom_addr),
        .rom_ack_i(ack), .rom_data_i(rdata), .rom_buf_o(rbuf),
        .dispatch_valid_o(dval), .dispatch_idx_o(didx), .src_sel_o(src),
        .dst_sel_o(dst), .status_o(status)
    );

    int checks = 0, errors = 0;
    int seed = 32'h5eed1234;
    bit done = 1'b0;

    // reference model state
    bit        m_go, m_a, m_b, m_both, m_busy;
    logic [15:0] m_pc;
    logic [7:0]  m_pipe, m_buf;
    logic [3:0]  m_src, m_dst;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit is_mode(input logic [7:0] op);
        return op == 8'h3D || op == 8'h3E || op == 8'h3F;
    endfunction

    function automatic bit is_sel(input logic [7:0] op);
        return op[7:4] == 4'h1 || op[7:4] == 4'h2 || op[7:4] == 4'hB;
    endfunction

    function automatic logic [15:0] exp_status();
        logic [15:0] s = '0;
        s[5] = m_go; s[6] = m_busy; s[8] = m_a; s[9] = m_b; s[12] = m_both;
        return s;
    endfunction

    function automatic logic [7:0] rand_op();
        int r = $urandom_range(99);
        if (r < 2)  return 8'h00;
        if (r < 22) return 8'h3D + 8'($urandom_range(2));
        if (r < 32) return {4'h1, (($urandom_range(3) == 0) ? 4'hE : 4'($urandom_range(15)))};
        if (r < 40) return {4'hB, 4'($urandom_range(15))};
        if (r < 48) return {4'h2, (($urandom_range(3) == 0) ? 4'hE : 4'($urandom_range(15)))};
        return 8'h40 + 8'($urandom_range(100));
    endfunction

    task automatic fill_mem(input bit plain);
        for (int i = 0; i < 256; i++) mem[i] = plain ? 8'h55 : rand_op();
    endtask

    // One cycle: drive inputs, compare against model, then advance model.
    task automatic cycle(input bit st, input logic [15:0] spc);
        bit e_valid;
        logic [7:0] fetched;
        logic [15:0] off;
        start = st; start_pc = spc;
        r14 = 16'($urandom); rdata = 8'($urandom);
        ack = ($urandom_range(3) == 0);
        if ($urandom_range(15) == 0) pbank = 8'($urandom);
        if ($urandom_range(15) == 0) rbank = 8'($urandom);
        #2;
        off = st ? spc : m_pc;
        e_valid = m_go && !st && !is_mode(m_pipe) && !is_sel(m_pipe);
        chk("R1 pmem_addr", 32'(paddr), 32'({pbank, off}));
        chk(m_go ? "R3 dispatch_valid" : "R8 dispatch_valid", 32'(dval), 32'(e_valid));
        chk("R2 dispatch_idx", 32'(didx), 32'({m_b, m_a, m_pipe}));
        chk("R5 src_sel", 32'(src), 32'(m_src));
        chk("R5 dst_sel", 32'(dst), 32'(m_dst));
        chk("R4 status", 32'(status), 32'(exp_status()));
        chk("R6 rom_rd", 32'(rom_rd), 32'(e_valid && m_dst == 4'hE));
        if (e_valid && m_dst == 4'hE) chk("R6 rom_addr", 32'(rom_addr), 32'({rbank, r14}));
        chk("R6 rom_buf", 32'(rbuf), 32'(m_buf));
        fetched = mem[paddr[7:0]];
        @(posedge clk);
        // data read tracker
        if (m_busy && ack) m_buf = rdata;
        if (e_valid && m_dst == 4'hE) m_busy = 1'b1;
        else if (ack) m_busy = 1'b0;
        if (st) begin
            m_go = 1'b1; m_pipe = fetched; m_pc = spc + 16'd1;
            m_a = 0; m_b = 0; m_both = 0; m_src = 0; m_dst = 0;
        end else if (m_go) begin
            logic [7:0] op = m_pipe;
            m_pipe = fetched; m_pc = m_pc + 16'd1;
            if (is_mode(op)) begin
                m_a = m_a | op[0]; m_b = m_b | op[1];
            end else if (op[7:4] == 4'h1) m_dst = op[3:0];
            else if (op[7:4] == 4'hB) m_src = op[3:0];
            else if (op[7:4] == 4'h2) begin
                m_src = op[3:0]; m_dst = op[3:0]; m_both = 1'b1;
            end else begin
                m_a = 0; m_b = 0; m_both = 0; m_src = 0; m_dst = 0;
                if (op == 8'h00) m_go = 1'b0;
            end
        end
        @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(seed));
        fill_mem(1'b0);
        m_go = 0; m_a = 0; m_b = 0; m_both = 0; m_busy = 0;
        m_pc = 0; m_pipe = 0; m_buf = 0; m_src = 0; m_dst = 0;
        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9 status", 32'(status), 32'h0);
        chk("R9 dispatch_valid", 32'(dval), 32'h0);
        chk("R9 rom_rd", 32'(rom_rd), 32'h0);
        chk("R9 sel", 32'({src, dst}), 32'h0);
        rst_n = 1'b1;
        // idle before any start: R8 hold
        repeat (5) cycle(1'b0, 16'h0);
        // directed R7 wrap: plain ordinary opcodes from 0xFFFE
        fill_mem(1'b1);
        cycle(1'b1, 16'hFFFE);
        cycle(1'b0, 16'h0);
        cycle(1'b0, 16'h0);
        chk("R7 wrap offset", 32'(paddr[15:0]), 32'h0001);
        chk("R7 bank kept", 32'(paddr[23:16]), 32'(pbank));
        // directed: mode chain then ordinary (R3, R2, R4)
        mem[8'h10] = 8'h3D; mem[8'h11] = 8'h3E; mem[8'h12] = 8'h1E; mem[8'h13] = 8'h77;
        cycle(1'b1, 16'h0010);
        repeat (3) cycle(1'b0, 16'h0);
        chk("R2 dispatch_idx mode both", 32'(didx), 32'h377);
        chk("R3 dispatch after chain", 32'(dval), 32'h1);
        chk("R6 rom_rd on dst14", 32'(rom_rd), 32'h1);
        cycle(1'b0, 16'h0);
        chk("R4 cleared", 32'({status[12], status[9:8], src, dst}), 32'h0);
        // random runs with restarts
        fill_mem(1'b0);
        for (int n = 0; n < 4000; n++) begin
            bit st = 1'b0;
            logic [15:0] spc = 16'($urandom);
            if (!m_go && $urandom_range(3) == 0) st = 1'b1;
            if (m_go && $urandom_range(199) == 0) st = 1'b1;
            if ($urandom_range(3) == 0) spc = 16'hFFF0 | 16'($urandom_range(15));
            if (st && $urandom_range(7) == 0) fill_mem(1'b0);
            cycle(st, spc);
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule